// File: doc/BRIEF.md
# Temperature Sensor Read Sequencer (two-wire serial master)

This block is a fixed-purpose two-wire serial (I2C) master that carries out one complete temperature read from a humidity/temperature sensor. A one-cycle `start` pulse launches the whole transaction. The block sends a START and the sensor address with the write direction, then the measure-temperature command. It follows with a repeated START, the sensor address with the read direction, and two result bytes. It ends with a STOP. The two received bytes are joined into one 16-bit raw code, with the first byte in the upper half. A one-cycle `done` strobe marks the code as valid.

The bus pins are open-drain. Each line has a "pull low" output and a line-level input, and the pad logic outside the block turns these into the actual open-drain driver. The sensor may hold the clock line low while it converts. The master releases the clock and then waits for the line to really go high before it counts a high phase. Bus timing comes from a divider parameter: each bit is split into four quarter periods of `CLK_DIV` system clocks. The line-level inputs are expected to be synchronous to `clk` already.

If the sensor refuses any byte the master sends, the block abandons the transaction, issues a STOP and pulses `error` in place of `done`.

Top module: `temp_i2c_reader`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, `temp_code` is 0, and both `scl_low` and `sda_low` are 0 (both lines released).
- R2: A `start` pulse while `busy` is low makes `busy` high in the next cycle. `busy` stays high until the closing STOP completes. A `start` while `busy` is high is ignored and does not begin a second transaction.
- R3: The bus sequence is: START, then address byte 0x80 (7-bit address 0x40 followed by write bit 0), then command byte 0xE3. After that comes a repeated START with no STOP before it, then address byte 0x81 (read bit 1), two received bytes, and STOP. Each byte goes most significant bit first, followed by a ninth acknowledge clock.
- R4: SDA changes while SCL is high only to form a START (SDA falls) or a STOP (SDA rises). A successful read shows exactly two STARTs and one STOP.
- R5: When the master has released SCL but the line stays low, the master keeps SCL released and keeps SDA unchanged until the line goes high. A result read with the clock held low by the sensor is still correct.
- R6: On success, `temp_code` = {first received byte, second received byte}. `done` is high for exactly one cycle, the same cycle in which `busy` falls, and `temp_code` is already valid in that cycle.
- R7: The master acknowledges the first received byte by driving SDA low on its ninth clock. It does not acknowledge the second byte: SDA is released (high) on its ninth clock.
- R8: An acknowledge bit sampled high after any byte the master sends (address or command) ends the transaction with a STOP. `error` then pulses for one cycle as `busy` falls, `done` stays low, and `temp_code` keeps its previous value.
- R9: Each SCL low phase driven by the master lasts at least `CLK_DIV` cycles, and each SCL high phase lasts at least 2*`CLK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run one temperature read |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle strobe: `temp_code` holds a new result |
| error | output | 1 | One-cycle strobe: the transaction was refused and aborted |
| temp_code | output | 16 | Raw 16-bit result, first received byte in bits 15:8 |
| scl_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_in | input | 1 | Level of the clock line |
| sda_in | input | 1 | Level of the data line |

## Verification
The hardest situation to reach is the sensor holding SCL low exactly when the master has just released it for a read bit. In that case the master must wait without sampling data or moving SDA. The bench contains a small behavioural sensor model that answers on the shared wired-AND lines. After acknowledging the read address, the model holds the clock low for a swept number of cycles: none, short, and longer than several quarter periods. The same model can refuse the address or the command byte. This drives the abort path from a refusal in each of the two write bytes, and a normal read runs right after each abort to show the block recovers.

// File: rtl/tr_pkg.sv
package tr_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 2 * BYTE_W;

    // Bus-level operations the bit engine can perform
    typedef enum logic [1:0] {
        BC_START,
        BC_STOP,
        BC_WRITE,
        BC_READ
    } bus_cmd_e;

    // Transaction steps of the sequencer
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR_WR,
        SQ_COMMAND,
        SQ_RESTART,
        SQ_ADDR_RD,
        SQ_READ_HI,
        SQ_READ_LO,
        SQ_STOP
    } seq_state_e;

endpackage

// File: rtl/tr_quarter_tick.sv
// Quarter-bit timebase: tick every CLK_DIV cycles, restartable.
module tr_quarter_tick #(
    parameter int CLK_DIV = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tr_bit_engine.sv
// Executes one bus operation (START, STOP, bit write, bit read) in four
// quarter phases; phase 1 waits for the clock line to really be high.
module tr_bit_engine
    import tr_pkg::*;
#(
    parameter int CLK_DIV = 250
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  bus_cmd_e cmd,
    input  logic     wbit,
    input  logic     scl_in,
    input  logic     sda_in,
    output logic     ready,
    output logic     op_done,
    output logic     rbit,
    output logic     scl_low,
    output logic     sda_low
);
    typedef struct packed {
        logic       active;
        bus_cmd_e   cmd;
        logic [1:0] phase;
        logic       scl_low;
        logic       sda_low;
        logic       rbit;
        logic       done;
    } eng_t;

    localparam eng_t ENG_RST = '{
        active:  1'b0,
        cmd:     BC_STOP,
        phase:   2'd0,
        scl_low: 1'b0,
        sda_low: 1'b0,
        rbit:    1'b1,
        done:    1'b0
    };

    eng_t e_d, e_q;
    logic tick;
    logic clr;

    tr_quarter_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .tick (tick)
    );

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        clr      = 1'b0;
        if (!e_q.active) begin
            if (go) begin
                e_d.active = 1'b1;
                e_d.cmd    = cmd;
                e_d.phase  = 2'd0;
                clr        = 1'b1;
                // phase 0: SCL low (or untouched for START), set up SDA
                unique case (cmd)
                    BC_WRITE: begin
                        e_d.scl_low = 1'b1;
                        e_d.sda_low = ~wbit;
                    end
                    BC_READ: begin
                        e_d.scl_low = 1'b1;
                        e_d.sda_low = 1'b0;
                    end
                    BC_START: begin
                        e_d.sda_low = 1'b0;
                    end
                    default: begin
                        e_d.scl_low = 1'b1;
                        e_d.sda_low = 1'b1;
                    end
                endcase
            end
        end else if (tick) begin
            unique case (e_q.phase)
                2'd0: begin
                    e_d.phase   = 2'd1;
                    e_d.scl_low = 1'b0;
                end
                2'd1: begin
                    // hold here while the line is still low (stretching)
                    if (scl_in) begin
                        e_d.phase = 2'd2;
                        if (e_q.cmd == BC_START) begin
                            e_d.sda_low = 1'b1;
                        end
                    end
                end
                2'd2: begin
                    e_d.phase = 2'd3;
                    if (e_q.cmd == BC_STOP) begin
                        e_d.sda_low = 1'b0;
                    end else if (e_q.cmd != BC_START) begin
                        e_d.rbit = sda_in;
                    end
                end
                default: begin
                    e_d.active = 1'b0;
                    e_d.done   = 1'b1;
                    if (e_q.cmd != BC_STOP) begin
                        e_d.scl_low = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= ENG_RST;
        end else begin
            e_q <= e_d;
        end
    end

    assign ready   = ~e_q.active;
    assign op_done = e_q.done;
    assign rbit    = e_q.rbit;
    assign scl_low = e_q.scl_low;
    assign sda_low = e_q.sda_low;

endmodule

// File: rtl/temp_i2c_reader.sv
// Fixed command-then-read transaction sequencer for a temperature sensor.
module temp_i2c_reader
    import tr_pkg::*;
#(
    parameter int             CLK_DIV  = 250,
    parameter logic [6:0]     DEV_ADDR = 7'h40,
    parameter logic [BYTE_W-1:0] MEAS_CMD = 8'hE3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [CODE_W-1:0] temp_code,
    output logic              scl_low,
    output logic              sda_low,
    input  logic              scl_in,
    input  logic              sda_in
);
    localparam int BIT_CW = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic [BIT_CW-1:0] bitn;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] hi;
        logic              nack;
        logic              busy;
        logic              done;
        logic              error;
        logic [CODE_W-1:0] code;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:    SQ_IDLE,
        pend:  1'b0,
        bitn:  '0,
        sh:    '0,
        hi:    '0,
        nack:  1'b0,
        busy:  1'b0,
        done:  1'b0,
        error: 1'b0,
        code:  '0
    };

    seq_t s_d, s_q;

    logic     eng_go;
    bus_cmd_e eng_cmd;
    logic     eng_wbit;
    logic     eng_ready;
    logic     eng_done;
    logic     eng_rbit;

    tr_bit_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .go      (eng_go),
        .cmd     (eng_cmd),
        .wbit    (eng_wbit),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .ready   (eng_ready),
        .op_done (eng_done),
        .rbit    (eng_rbit),
        .scl_low (scl_low),
        .sda_low (sda_low)
    );

    // Which bus operation the current step needs
    always_comb begin
        eng_cmd  = BC_STOP;
        eng_wbit = 1'b1;
        unique case (s_q.st)
            SQ_START, SQ_RESTART: eng_cmd = BC_START;
            SQ_ADDR_WR, SQ_COMMAND, SQ_ADDR_RD: begin
                if (s_q.bitn < ACK_SLOT) begin
                    eng_cmd  = BC_WRITE;
                    eng_wbit = s_q.sh[BYTE_W-1];
                end else begin
                    eng_cmd = BC_READ;
                end
            end
            SQ_READ_HI, SQ_READ_LO: begin
                if (s_q.bitn < ACK_SLOT) begin
                    eng_cmd = BC_READ;
                end else begin
                    eng_cmd  = BC_WRITE;
                    eng_wbit = (s_q.st == SQ_READ_LO);
                end
            end
            default: eng_cmd = BC_STOP;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.error = 1'b0;
        eng_go    = 1'b0;

        if (s_q.st == SQ_IDLE) begin
            if (start) begin
                s_d.st   = SQ_START;
                s_d.busy = 1'b1;
                s_d.nack = 1'b0;
                s_d.pend = 1'b0;
            end
        end else begin
            if (!s_q.pend && eng_ready) begin
                eng_go   = 1'b1;
                s_d.pend = 1'b1;
            end
            if (eng_done) begin
                s_d.pend = 1'b0;
                unique case (s_q.st)
                    SQ_START: begin
                        s_d.st   = SQ_ADDR_WR;
                        s_d.sh   = {DEV_ADDR, 1'b0};
                        s_d.bitn = '0;
                    end
                    SQ_RESTART: begin
                        s_d.st   = SQ_ADDR_RD;
                        s_d.sh   = {DEV_ADDR, 1'b1};
                        s_d.bitn = '0;
                    end
                    SQ_ADDR_WR, SQ_COMMAND, SQ_ADDR_RD: begin
                        if (s_q.bitn < ACK_SLOT) begin
                            s_d.sh   = {s_q.sh[BYTE_W-2:0], 1'b0};
                            s_d.bitn = s_q.bitn + 1'b1;
                        end else if (eng_rbit) begin
                            s_d.nack = 1'b1;
                            s_d.st   = SQ_STOP;
                        end else begin
                            s_d.bitn = '0;
                            if (s_q.st == SQ_ADDR_WR) begin
                                s_d.st = SQ_COMMAND;
                                s_d.sh = MEAS_CMD;
                            end else if (s_q.st == SQ_COMMAND) begin
                                s_d.st = SQ_RESTART;
                            end else begin
                                s_d.st = SQ_READ_HI;
                            end
                        end
                    end
                    SQ_READ_HI, SQ_READ_LO: begin
                        if (s_q.bitn < ACK_SLOT) begin
                            s_d.sh   = {s_q.sh[BYTE_W-2:0], eng_rbit};
                            s_d.bitn = s_q.bitn + 1'b1;
                        end else if (s_q.st == SQ_READ_HI) begin
                            s_d.hi   = s_q.sh;
                            s_d.st   = SQ_READ_LO;
                            s_d.bitn = '0;
                        end else begin
                            s_d.st = SQ_STOP;
                        end
                    end
                    default: begin
                        s_d.st   = SQ_IDLE;
                        s_d.busy = 1'b0;
                        if (s_q.nack) begin
                            s_d.error = 1'b1;
                        end else begin
                            s_d.done = 1'b1;
                            s_d.code = {s_q.hi, s_q.sh};
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign error     = s_q.error;
    assign temp_code = s_q.code;

endmodule

// File: rtl/temp_i2c_reader_chk.sv
module temp_i2c_reader_chk #(
    parameter int CLK_DIV = 250
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic error,
    input logic scl_low,
    input logic sda_low,
    input logic scl_in
);
    localparam int CW = $clog2(4 * CLK_DIV + 2);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] lo_cnt_q, hi_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            lo_cnt_q <= scl_low ? ((lo_cnt_q == CMAX) ? CMAX : lo_cnt_q + 1'b1) : '0;
            hi_cnt_q <= (scl_in && !scl_low) ?
                        ((hi_cnt_q == CMAX) ? CMAX : hi_cnt_q + 1'b1) : '0;
        end
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || error));

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R8
    err_busy_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (!busy && $past(busy)));

    // R5
    stretch_scl_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_low && !scl_in) |=> !scl_low);

    // R5
    stretch_sda_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_low && !scl_in) |=> $stable(sda_low));

    // R9
    low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_low) |-> (lo_cnt_q >= CW'(CLK_DIV)));

    // R9
    high_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> (hi_cnt_q >= CW'(2 * CLK_DIV)));

endmodule

bind temp_i2c_reader temp_i2c_reader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .scl_in  (scl_in)
);

// File: tb/tb_temp_i2c_reader.sv
module tb_temp_i2c_reader;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, error, scl_low, sda_low;
    logic [15:0] temp_code;
    logic scl_in, sda_in;

    always #4 clk = ~clk;

    // sensor model side of the wired-AND bus
    logic s_scl_pull = 1'b0;
    logic s_sda_pull = 1'b0;
    assign scl_in = ~(scl_low | s_scl_pull);
    assign sda_in = ~(sda_low | s_sda_pull);

    temp_i2c_reader #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .error(error), .temp_code(temp_code), .scl_low(scl_low),
        .sda_low(sda_low), .scl_in(scl_in), .sda_in(sda_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // sensor model configuration (driven from the stimulus process)
    logic [15:0] cfg_val = 16'h0;
    int  cfg_stretch = 0;
    bit  cfg_nack_addr = 0;
    bit  cfg_nack_cmd = 0;
    bit  log_clr = 0;

    // sensor model state and logs
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int   s_mode = 0;  // 0 idle, 1 receive, 2 transmit
    int   cnt = 0;
    bit   first = 0;
    bit   acked = 0;
    logic [7:0] rx_sh = 8'h0;
    logic [7:0] tx_sh = 8'h0;
    int   tx_idx = 0;
    int   stretch_cnt = 0;
    int   n_start = 0, n_stop = 0, done_cnt = 0, err_cnt = 0;
    logic [7:0] rx_log [4];
    int   rx_n = 0;
    logic m_ack [2];
    int   m_ack_n = 0;
    int   lo_run = 0, hi_run = 0, min_lo = 1000000, min_hi = 1000000;

    always @(posedge clk) begin
        if (done)  done_cnt <= done_cnt + 1;
        if (error) err_cnt  <= err_cnt + 1;
    end

    always @(posedge clk) begin
        prev_scl <= scl_in;
        prev_sda <= sda_in;
        if (stretch_cnt > 0) begin
            stretch_cnt <= stretch_cnt - 1;
            if (stretch_cnt == 1) s_scl_pull <= 1'b0;
        end
        // phase length measurement
        if (!prev_scl && scl_in) begin
            if (busy && lo_run < min_lo) min_lo <= lo_run;
            lo_run <= 0;
            hi_run <= 1;
        end else if (prev_scl && !scl_in) begin
            if (busy && hi_run < min_hi) min_hi <= hi_run;
            hi_run <= 0;
            lo_run <= 1;
        end else if (scl_in) begin
            hi_run <= hi_run + 1;
        end else begin
            lo_run <= lo_run + 1;
        end
        // protocol
        if (prev_scl && scl_in && prev_sda && !sda_in) begin
            n_start <= n_start + 1;
            s_mode  <= 1;
            cnt     <= 0;
            first   <= 1;
        end else if (prev_scl && scl_in && !prev_sda && sda_in) begin
            n_stop     <= n_stop + 1;
            s_mode     <= 0;
            s_sda_pull <= 1'b0;
        end else if (!prev_scl && scl_in) begin
            if (s_mode == 1) begin
                if (cnt < 8) begin
                    rx_sh <= {rx_sh[6:0], sda_in};
                    cnt   <= cnt + 1;
                end else if (cnt == 8) begin
                    cnt <= 9;
                end
            end else if (s_mode == 2) begin
                if (cnt < 8) begin
                    cnt <= cnt + 1;
                end else if (cnt == 8) begin
                    if (m_ack_n < 2) m_ack[m_ack_n] <= sda_in;
                    m_ack_n <= m_ack_n + 1;
                    cnt <= 9;
                end
            end
        end else if (prev_scl && !scl_in) begin
            if (s_mode == 1) begin
                if (cnt == 8) begin
                    if (rx_n < 4) rx_log[rx_n] <= rx_sh;
                    rx_n <= rx_n + 1;
                    if (first) begin
                        acked      <= (rx_sh[7:1] == 7'h40) && !cfg_nack_addr;
                        s_sda_pull <= (rx_sh[7:1] == 7'h40) && !cfg_nack_addr;
                    end else begin
                        acked      <= (rx_sh == 8'hE3) && !cfg_nack_cmd;
                        s_sda_pull <= (rx_sh == 8'hE3) && !cfg_nack_cmd;
                    end
                end else if (cnt == 9) begin
                    s_sda_pull <= 1'b0;
                    cnt        <= 0;
                    first      <= 0;
                    if (!acked) begin
                        s_mode <= 0;
                    end else if (first && rx_sh[0]) begin
                        s_mode     <= 2;
                        tx_sh      <= cfg_val[15:8];
                        tx_idx     <= 0;
                        s_sda_pull <= ~cfg_val[15];
                        if (cfg_stretch > 0) begin
                            s_scl_pull  <= 1'b1;
                            stretch_cnt <= cfg_stretch;
                        end
                    end
                end
            end else if (s_mode == 2) begin
                if (cnt < 8) begin
                    s_sda_pull <= ~tx_sh[7 - cnt];
                end else if (cnt == 8) begin
                    s_sda_pull <= 1'b0;
                end else begin
                    if (tx_idx == 0) begin
                        tx_sh      <= cfg_val[7:0];
                        tx_idx     <= 1;
                        cnt        <= 0;
                        s_sda_pull <= ~cfg_val[7];
                    end else begin
                        s_mode     <= 0;
                        s_sda_pull <= 1'b0;
                    end
                end
            end
        end
        if (log_clr) begin
            rx_n    <= 0;
            m_ack_n <= 0;
            min_lo  <= 1000000;
            min_hi  <= 1000000;
        end
    end

    int base_len = 0;

    task automatic run_txn(input logic [15:0] val, input int stretch,
                           input bit na, input bit nc, input bit extra);
        int s0, p0, d0, e0, len;
        logic [15:0] old_code;
        bit good;
        good = !(na || nc);
        @(negedge clk);
        cfg_val = val; cfg_stretch = stretch;
        cfg_nack_addr = na; cfg_nack_cmd = nc;
        log_clr = 1;
        @(negedge clk);
        log_clr = 0;
        s0 = n_start; p0 = n_stop; d0 = done_cnt; e0 = err_cnt;
        old_code = temp_code;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        len = 1;
        if (extra) begin
            repeat (40) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
            len += 41;
        end
        while (busy && len < 20000) begin
            @(negedge clk);
            len++;
        end
        chk(!busy, "R2", "transaction ended", busy, 0);
        chk(done == good, "R6", "done at busy fall", done, good);
        chk(error == !good, "R8", "error at busy fall", error, !good);
        if (good)
            chk(temp_code == val, "R6", "result word", temp_code, val);
        else
            chk(temp_code == old_code, "R8", "result kept", temp_code, old_code);
        @(negedge clk);
        chk(!done && !error, "R6", "strobe width one cycle", {done, error}, 0);
        repeat (3) @(negedge clk);
        chk(!busy, "R2", "no second transaction", busy, 0);
        chk(done_cnt - d0 == int'(good), "R2", "done pulse count", done_cnt - d0, int'(good));
        chk(err_cnt - e0 == int'(!good), "R8", "error pulse count", err_cnt - e0, int'(!good));
        chk(n_stop - p0 == 1, "R4", "STOP count", n_stop - p0, 1);
        if (good) begin
            chk(n_start - s0 == 2, "R4", "START count", n_start - s0, 2);
            chk(rx_n == 3, "R3", "bytes seen by sensor", rx_n, 3);
            chk(rx_log[0] == 8'h80, "R3", "write address byte", rx_log[0], 8'h80);
            chk(rx_log[1] == 8'hE3, "R3", "command byte", rx_log[1], 8'hE3);
            chk(rx_log[2] == 8'h81, "R3", "read address byte", rx_log[2], 8'h81);
            chk(m_ack_n == 2, "R7", "master ack slots", m_ack_n, 2);
            chk(m_ack[0] == 1'b0, "R7", "ack on first byte", m_ack[0], 0);
            chk(m_ack[1] == 1'b1, "R7", "nack on second byte", m_ack[1], 1);
            chk(min_lo >= DIV, "R9", "min SCL low", min_lo, DIV);
            chk(min_hi >= 2 * DIV, "R9", "min SCL high", min_hi, 2 * DIV);
            if (stretch == 0 && !extra && base_len == 0) base_len = len;
            if (stretch > 0 && base_len > 0)
                chk(len >= base_len + stretch - 2 * DIV, "R5", "waited through stretch",
                    len, base_len + stretch - 2 * DIV);
        end else begin
            chk(n_start - s0 == 1, "R8", "no repeated START after refusal", n_start - s0, 1);
            chk(rx_n == (na ? 1 : 2), "R8", "bytes sent before abort", rx_n, na ? 1 : 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error, "R1", "flags in reset", {busy, done, error}, 0);
        chk(!scl_low && !sda_low, "R1", "lines released in reset", {scl_low, sda_low}, 0);
        chk(temp_code == 16'h0, "R1", "result in reset", temp_code, 0);
        rst = 0;
        repeat (5) @(negedge clk);
        chk(!busy && !scl_low && !sda_low, "R1", "idle after reset", {busy, scl_low, sda_low}, 0);

        run_txn(16'hA55A, 0, 0, 0, 0);
        run_txn(16'h0000, 0, 0, 0, 0);
        run_txn(16'hFFFF, 5, 0, 0, 0);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] hb, lb;
            hb = 8'(i * 37 + 5);
            lb = 8'(255 - i * 29);
            run_txn({hb, lb}, (i % 3) * 23, 0, 0, 0);
        end
        // R2: second start during a transaction is ignored
        run_txn(16'h1234, 0, 0, 0, 1);
        // R8: refusals of address and of command, then recovery with stretch (R5)
        run_txn(16'h7777, 0, 1, 0, 0);
        run_txn(16'h6666, 0, 0, 1, 0);
        run_txn(16'h8001, 60, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual 0x%0h expected 0x%0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule